// File: doc/BRIEF.md
# Shared-Pool Central Buffer Switch

This block is an N-by-N packet switch in which every port shares one central data memory instead of owning a private FIFO. Each packet is a single word that fills exactly one slot of the pool. An arriving word carries a destination field. It takes a slot index from a free-slot ring, its data is written into that slot, and the slot index is appended to the pointer queue of the destination output. Each output reads its own pointer queue in order, fetches the word from the pool, and hands the slot index back to the free ring.

The memory is time-multiplexed on one clock. A link cycle (a frame) lasts 2N+1 clocks. In the first N clocks each input in turn gets one write slot, in index order. In the next N clocks each output in turn gets one read slot, in index order. The last clock is a turnaround that lets the final registered read land. The pool therefore runs at roughly twice the port rate, which is enough for every input and every output to move one word per link cycle. A mark pulse shows the frame boundary. Ports drive and sample their link signals once per frame, in the marked clock.

Top module: `shared_pool_switch`

## Requirements
- R1: After reset no output is valid, every acknowledge is low, the full flag is low, the pool has SLOTS free slots, and the mark is high in the first clock.
- R2: `link_mark` is high for exactly one clock in every 2*NP+1 clocks. Inputs must be held stable from a marked clock until the next one. `out_ready` is sampled at the end of the marked clock.
- R3: Suppose a word is accepted in one frame, and its output's holding register and pointer queue are empty at that frame's read phase. The word is then presented at the next marked clock.
- R4: While an output has queued words and its `out_ready` is high in every marked clock, it presents a new word at every mark, whatever mix of destinations the inputs send.
- R5: Within a frame, valid inputs are accepted in ascending port index while free slots remain. `in_ack[i]` at the next mark is 1 exactly when input i was accepted.
- R6: In a marked clock, `pool_full` is 1 exactly when no slot is free.
- R7: Each output delivers words in arrival order. Words that reach one output in the same frame are ordered by input index.
- R8: An output held with `out_ready` low never delays words bound for any other output.
- R9: A rejected word has no effect. It is never delivered and takes no slot.
- R10: A presented word stays valid with stable data until a marked clock in which its `out_ready` is high.
- R11: A slot returns to the free ring when its output reads it. Once all words have drained, the full capacity of SLOTS is available again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pool clock; one frame is 2*NP+1 cycles |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NP | Per-input word present, held for the frame |
| in_dest | input | NP*PW | Per-input destination output index, PW bits each |
| in_data | input | NP*DW | Per-input data word |
| in_ack | output | NP | Per-input acceptance result of the last frame |
| pool_full | output | 1 | No free slot in the pool |
| out_ready | input | NP | Per-output consume strobe, sampled in the marked clock |
| out_valid | output | NP | Per-output word presented |
| out_data | output | NP*DW | Per-output presented word |
| link_mark | output | 1 | Marks the clock in which ports sample and drive |

## Verification
The hardest situation to reach is a frame that only partly fits. Free slots run out partway through the write phase, so the low-indexed inputs are accepted and the high-indexed ones are turned away. At the same time, outputs hold words that have already left the pool. To get there, the stimulus holds every output not ready while all inputs stream in. Once the holding registers are full, each frame drains four slots. One frame then sends only two words, which leaves exactly two free slots before a frame in which all four inputs are valid. After that, a full drain checks that the delivered sequences leave out the rejected words and that capacity comes back.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [1:0] {
    PK_WRITE = 2'd0,
    PK_READ  = 2'd1,
    PK_TURN  = 2'd2
  } phase_kind_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sps_phase_gen.sv
module sps_phase_gen
  import sps_pkg::*;
#(
  parameter int NP = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  output phase_kind_e            kind,
  output logic [idx_w(NP)-1:0]   port_idx,
  output logic                   first_edge,
  output logic                   mark
);
  localparam int PW   = idx_w(NP);
  localparam int LAST = 2 * NP;
  localparam int PHW  = $clog2(LAST + 1);
  localparam logic [PHW-1:0] PH_LAST = PHW'(LAST);
  localparam logic [PHW-1:0] PH_NP   = PHW'(NP);
  localparam logic [PHW-1:0] PH_2NP  = PHW'(2 * NP);

  logic [PHW-1:0] ph;
  logic [PHW-1:0] rd_off;
  logic           mark_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      mark_q <= 1'b1;
    end else if (ph == PH_LAST) begin
      ph     <= '0;
      mark_q <= 1'b1;
    end else begin
      ph     <= ph + 1'b1;
      mark_q <= 1'b0;
    end
  end

  assign rd_off = ph - PH_NP;

  always_comb begin
    if (ph < PH_NP) begin
      kind     = PK_WRITE;
      port_idx = ph[PW-1:0];
    end else if (ph < PH_2NP) begin
      kind     = PK_READ;
      port_idx = rd_off[PW-1:0];
    end else begin
      kind     = PK_TURN;
      port_idx = '0;
    end
  end

  assign first_edge = (ph == '0);
  assign mark       = mark_q;

endmodule

// File: rtl/sps_index_ring.sv
module sps_index_ring
  import sps_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter bit PRELOAD = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        push,
  input  logic [idx_w(DEPTH)-1:0]     push_val,
  input  logic                        pop,
  output logic [idx_w(DEPTH)-1:0]     head_val,
  output logic [cnt_w(DEPTH)-1:0]     count
);
  localparam int AW = idx_w(DEPTH);
  localparam int CW = cnt_w(DEPTH);
  localparam logic [AW-1:0] TOP      = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_INIT = PRELOAD ? CW'(DEPTH) : '0;

  logic [AW-1:0] store [DEPTH];
  logic [AW-1:0] rd_p;
  logic [AW-1:0] wr_p;
  logic [CW-1:0] cnt_q;

  generate
    if (PRELOAD) begin : g_preload
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int k = 0; k < DEPTH; k++) store[k] <= AW'(k);
        end else if (push) begin
          store[wr_p] <= push_val;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (push) store[wr_p] <= push_val;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p  <= '0;
      wr_p  <= '0;
      cnt_q <= CNT_INIT;
    end else begin
      if (push) wr_p <= (wr_p == TOP) ? '0 : wr_p + 1'b1;
      if (pop)  rd_p <= (rd_p == TOP) ? '0 : rd_p + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_val = store[rd_p];
  assign count    = cnt_q;

endmodule

// File: rtl/sps_pool_mem.sv
module sps_pool_mem
  import sps_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SLOTS = 16
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [idx_w(SLOTS)-1:0]   waddr,
  input  logic [DW-1:0]             wdata,
  input  logic                      re,
  input  logic [idx_w(SLOTS)-1:0]   raddr,
  output logic [DW-1:0]             rdata
);
  logic [DW-1:0] cells [SLOTS];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= cells[raddr];
  end

endmodule

// File: rtl/shared_pool_switch.sv
module shared_pool_switch
  import sps_pkg::*;
#(
  parameter int NP    = 4,
  parameter int DW    = 16,
  parameter int SLOTS = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NP-1:0]             in_valid,
  input  logic [NP*idx_w(NP)-1:0]   in_dest,
  input  logic [NP*DW-1:0]          in_data,
  output logic [NP-1:0]             in_ack,
  output logic                      pool_full,
  input  logic [NP-1:0]             out_ready,
  output logic [NP-1:0]             out_valid,
  output logic [NP*DW-1:0]          out_data,
  output logic                      link_mark
);
  localparam int PW = idx_w(NP);
  localparam int AW = idx_w(SLOTS);
  localparam int CW = cnt_w(SLOTS);

  phase_kind_e    kind;
  logic [PW-1:0]  pidx;
  logic           first_edge;

  logic           wr_act;
  logic           cur_v;
  logic [PW-1:0]  cur_dest;
  logic [DW-1:0]  cur_data;
  logic           accept;

  logic [AW-1:0]  fl_head;
  logic [CW-1:0]  fl_cnt;
  logic           fl_empty;

  logic [AW-1:0]  q_head  [NP];
  logic [CW-1:0]  q_cnt   [NP];
  logic [NP-1:0]  q_empty;
  logic [NP*CW-1:0] q_cnt_all;

  logic           rd_go;
  logic [AW-1:0]  rd_slot;
  logic [DW-1:0]  rdata;
  logic           pend;
  logic [PW-1:0]  pend_j;

  logic [NP-1:0]  hold_v;
  logic [DW-1:0]  hold_d [NP];
  logic [NP-1:0]  ack_q;

  sps_phase_gen #(.NP(NP)) phase_i (
    .clk        (clk),
    .rst        (rst),
    .kind       (kind),
    .port_idx   (pidx),
    .first_edge (first_edge),
    .mark       (link_mark)
  );

  // write side: one input per clock during the write phase
  assign wr_act   = (kind == PK_WRITE);
  assign cur_v    = in_valid[pidx];
  assign cur_dest = in_dest[pidx*PW +: PW];
  assign cur_data = in_data[pidx*DW +: DW];
  assign fl_empty = (fl_cnt == '0);
  assign accept   = wr_act && cur_v && !fl_empty;

  // read side: one output per clock during the read phase
  assign rd_slot = q_head[pidx];
  assign rd_go   = (kind == PK_READ) && !hold_v[pidx] && !q_empty[pidx];

  sps_index_ring #(.DEPTH(SLOTS), .PRELOAD(1'b1)) free_ring_i (
    .clk      (clk),
    .rst      (rst),
    .push     (rd_go),
    .push_val (rd_slot),
    .pop      (accept),
    .head_val (fl_head),
    .count    (fl_cnt)
  );

  generate
    for (genvar j = 0; j < NP; j++) begin : g_outq
      logic q_push;
      logic q_pop;
      assign q_push = accept && (cur_dest == PW'(j));
      assign q_pop  = rd_go  && (pidx == PW'(j));

      sps_index_ring #(.DEPTH(SLOTS), .PRELOAD(1'b0)) ptr_q_i (
        .clk      (clk),
        .rst      (rst),
        .push     (q_push),
        .push_val (fl_head),
        .pop      (q_pop),
        .head_val (q_head[j]),
        .count    (q_cnt[j])
      );

      assign q_empty[j] = (q_cnt[j] == '0);
      assign q_cnt_all[j*CW +: CW] = q_cnt[j];

      always_ff @(posedge clk) begin
        if (rst) begin
          hold_v[j] <= 1'b0;
          hold_d[j] <= '0;
        end else if (pend && (pend_j == PW'(j))) begin
          hold_v[j] <= 1'b1;
          hold_d[j] <= rdata;
        end else if (first_edge && hold_v[j] && out_ready[j]) begin
          hold_v[j] <= 1'b0;
        end
      end

      assign out_data[j*DW +: DW] = hold_d[j];
    end
  endgenerate

  sps_pool_mem #(.DW(DW), .SLOTS(SLOTS)) pool_i (
    .clk   (clk),
    .we    (accept),
    .waddr (fl_head),
    .wdata (cur_data),
    .re    (rd_go),
    .raddr (rd_slot),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      pend_j <= '0;
    end else begin
      pend   <= rd_go;
      pend_j <= pidx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= '0;
    end else if (wr_act) begin
      ack_q[pidx] <= accept;
    end
  end

  assign in_ack    = ack_q;
  assign out_valid = hold_v;
  assign pool_full = fl_empty;

endmodule

// File: rtl/sps_checker.sv
module sps_checker
  import sps_pkg::*;
#(
  parameter int NP    = 4,
  parameter int DW    = 16,
  parameter int SLOTS = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       link_mark,
  input logic [NP-1:0]              out_valid,
  input logic [NP-1:0]              out_ready,
  input logic [NP*DW-1:0]           out_data,
  input logic [cnt_w(SLOTS)-1:0]    fl_cnt,
  input logic [NP*cnt_w(SLOTS)-1:0] q_cnt_all
);
  localparam int CW = cnt_w(SLOTS);

  int occ;
  always_comb begin
    occ = 0;
    for (int k = 0; k < NP; k++) occ += int'(q_cnt_all[k*CW +: CW]);
  end

  AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    link_mark |=> !link_mark); // R2

  AST_SLOT_CONSERVE: assert property (@(posedge clk) disable iff (rst)
    (int'(fl_cnt) + occ) == SLOTS); // R11

  generate
    for (genvar j = 0; j < NP; j++) begin : g_port
      AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid[j] && !(link_mark && out_ready[j]))
          |=> (out_valid[j] && $stable(out_data[j*DW +: DW]))); // R10

      AST_DROP_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid[j]) |-> $past(link_mark && out_ready[j])); // R10
    end
  endgenerate

endmodule

bind shared_pool_switch sps_checker #(.NP(NP), .DW(DW), .SLOTS(SLOTS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .link_mark (link_mark),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .fl_cnt    (fl_cnt),
  .q_cnt_all (q_cnt_all)
);

// File: tb/shared_pool_switch_tb_top.sv
module shared_pool_switch_tb_top;
  localparam int NP    = 4;
  localparam int DW    = 16;
  localparam int SLOTS = 16;
  localparam int PW    = 2;
  localparam int MQ    = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NP-1:0]    in_valid = '0;
  logic [NP*PW-1:0] in_dest  = '0;
  logic [NP*DW-1:0] in_data  = '0;
  logic [NP-1:0]    in_ack;
  logic             pool_full;
  logic [NP-1:0]    out_ready = '0;
  logic [NP-1:0]    out_valid;
  logic [NP*DW-1:0] out_data;
  logic             link_mark;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  // reference model state
  logic [DW-1:0] mqd [NP][MQ];
  int            mh [NP];
  int            mt [NP];
  bit            hv [NP];
  logic [DW-1:0] hd [NP];
  bit            mack [NP];
  int            mfree;

  always #10 clk = ~clk;

  shared_pool_switch #(.NP(NP), .DW(DW), .SLOTS(SLOTS)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_dest   (in_dest),
    .in_data   (in_data),
    .in_ack    (in_ack),
    .pool_full (pool_full),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .link_mark (link_mark)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wait_mark();
    do @(negedge clk); while (!link_mark);
  endtask

  // one link cycle: compare outputs against the model, then drive and advance
  task automatic frame(input logic [NP-1:0] v, input logic [NP*PW-1:0] d,
                       input logic [DW-1:0] base, input logic [NP-1:0] rdy,
                       input string tag);
    wait_mark();
    for (int j = 0; j < NP; j++) begin
      chk(out_valid[j] == hv[j], tag, $sformatf("out_valid[%0d]", j),
          int'(out_valid[j]), int'(hv[j]));
      if (hv[j])
        chk(out_data[j*DW +: DW] == hd[j], tag, $sformatf("out_data[%0d]", j),
            int'(out_data[j*DW +: DW]), int'(hd[j]));
      chk(in_ack[j] == mack[j], "R5", $sformatf("in_ack[%0d]", j),
          int'(in_ack[j]), int'(mack[j]));
    end
    chk(pool_full == (mfree == 0), "R6", "pool_full", int'(pool_full), int'(mfree == 0));
    for (int i = 0; i < NP; i++) begin
      in_data[i*DW +: DW] = base + DW'(i);
    end
    in_valid  = v;
    in_dest   = d;
    out_ready = rdy;
    // model: consume, writes in index order, reads in index order
    for (int j = 0; j < NP; j++) if (hv[j] && rdy[j]) hv[j] = 1'b0;
    for (int i = 0; i < NP; i++) begin
      if (v[i] && mfree > 0) begin
        int dst;
        dst = int'(d[i*PW +: PW]);
        mqd[dst][mt[dst] % MQ] = base + DW'(i);
        mt[dst]++;
        mfree--;
        mack[i] = 1'b1;
      end else begin
        mack[i] = 1'b0;
      end
    end
    for (int j = 0; j < NP; j++) begin
      if (!hv[j] && (mt[j] > mh[j])) begin
        hv[j] = 1'b1;
        hd[j] = mqd[j][mh[j] % MQ];
        mh[j]++;
        mfree++;
      end
    end
    @(posedge clk);
  endtask

  function automatic bit model_empty();
    bit e;
    e = 1'b1;
    for (int j = 0; j < NP; j++) if (hv[j] || (mt[j] > mh[j])) e = 1'b0;
    return e;
  endfunction

  task automatic drain(input string tag);
    for (int k = 0; k < 40 && !model_empty(); k++)
      frame('0, '0, 16'h0000, '1, tag);
    frame('0, '0, 16'h0000, '1, tag);
  endtask

  task automatic t_reset();
    chk(out_valid == '0, "R1", "out_valid", int'(out_valid), 0);
    chk(in_ack == '0, "R1", "in_ack", int'(in_ack), 0);
    chk(pool_full == 1'b0, "R1", "pool_full", int'(pool_full), 0);
    chk(link_mark == 1'b1, "R1", "link_mark", int'(link_mark), 1);
  endtask

  task automatic t_period();
    int gap;
    wait_mark();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!link_mark);
    chk(gap == 2*NP+1, "R2", "frame length", gap, 2*NP+1);
    @(posedge clk);
  endtask

  task automatic t_single();
    frame(4'b0100, 8'b00_01_00_00, 16'h1100, '1, "R3");
    frame('0, '0, 16'h0, '1, "R3");
    frame('0, '0, 16'h0, '1, "R3");
  endtask

  task automatic t_spread();
    frame(4'b1111, 8'b00_01_10_11, 16'h2200, '1, "R4");
    for (int k = 0; k < 4; k++)
      frame(4'b1111, {2'(k), 2'(k+1), 2'(k+2), 2'(k+3)}, 16'h2300 + 16'(k*16), '1, "R4");
    drain("R4");
  endtask

  task automatic t_same_dest();
    frame(4'b1111, 8'b10_10_10_10, 16'h3300, '1, "R7");
    frame(4'b0101, 8'b10_10_10_10, 16'h3400, '1, "R7");
    drain("R7");
  endtask

  task automatic t_hol();
    for (int k = 0; k < 5; k++)
      frame(4'b0011, 8'b00_00_01_00, 16'h4400 + 16'(k*16), 4'b1110, (k < 3) ? "R8" : "R10");
    frame('0, '0, 16'h0, 4'b1110, "R10");
    drain("R8");
  endtask

  task automatic t_fill();
    for (int k = 0; k < 4; k++)
      frame(4'b1111, 8'b11_10_01_00, 16'h5500 + 16'(k*16), 4'b0000, "R6");
    frame(4'b1010, 8'b11_10_01_00, 16'h5600, 4'b0000, "R5");
    frame(4'b1111, 8'b11_10_01_00, 16'h5700, 4'b0000, "R5");
    frame(4'b1111, 8'b00_00_00_00, 16'h5800, 4'b0000, "R9");
    frame('0, '0, 16'h0, 4'b0000, "R6");
    drain("R9");
  endtask

  task automatic t_refill();
    for (int k = 0; k < 5; k++)
      frame(4'b1111, 8'b00_01_10_11, 16'h6600 + 16'(k*16), 4'b0000, "R11");
    frame('0, '0, 16'h0, 4'b0000, "R11");
    drain("R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < NP; j++) begin
      mh[j] = 0; mt[j] = 0; hv[j] = 1'b0; hd[j] = '0; mack[j] = 1'b0;
    end
    mfree = SLOTS;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_period();
    t_single();
    t_spread();
    t_same_dest();
    t_hol();
    t_fill();
    t_refill();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule